// File: doc/BRIEF.md
# Queued Stepper Motor Controller

This block drives one stepper motor from a small memory-mapped register bus. Software sets a step total and a step interval, then writes a command word. The controller produces the four-phase full-step pattern and the two bridge enables for an external driver. It advances one phase position every interval until the total has been covered. A single-step command moves the motor by exactly one position without using the interval or the total.

A free-running prescaler divides the system clock down to a 10 kHz base tick, and the interval is counted in those ticks. The controller has one staging slot. A move can be queued while another is still running, and the queued move takes over as soon as the running move has stepped its last position. Software can see a running flag and a slot-occupied flag. An interrupt line is high whenever the slot is free, so the next move can be queued from an interrupt handler with no gap between moves.

Top module: `stepper_ctl`

## Requirements
- R1: After reset all phase and bridge-enable outputs are low. The running and slot-occupied flags read 0, the interrupt is high, drive is disabled and the phase position is the first state of the sequence.
- R2: The register offset selects the register: 0 is the command/status word, 1 is the step total, 2 is the interval. In the command word, bit 7 is the running flag (read only), bit 6 is the slot-occupied flag (read only), bit 5 is drive enable, bit 2 starts a move, bit 1 requests a single step and bit 0 is the direction. Reading offset 1 returns the steps still to go in the running move. Reading offset 2 returns the staged interval.
- R3: Successive steps of a move are exactly interval × PRESCALE clock cycles apart. An interval of 0 behaves as 1.
- R4: A start written while a move is running sets the slot-occupied flag. The flag stays set, and the staged total, interval and direction stay staged, until the running move has finished. The staged move then starts and the flag clears.
- R5: A move with total N makes exactly N steps. The running flag then returns to 0 and the remaining count reads 0.
- R6: While drive is enabled, the phase outputs (bit 3 down to bit 0) cycle through 0011, 0110, 1100, 1001 in that order when direction is 1, and in the reverse order when it is 0. They hold their value while no step is taken, and both bridge enables are 1.
- R7: A single-step request made while idle moves the phase exactly one position in the direction given in the same write. It starts no move and ignores the total, the interval and the start bit. A single-step request made while a move is running or staged is ignored.
- R8: With drive disabled, all phase and bridge-enable outputs are 0. The phase position is kept, and enabling drive again restores the same phase output.
- R9: The interrupt output is the inverse of the slot-occupied flag.
- R10: A start with a total of 0 makes no step and leaves the running flag at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| phase_o | output | 4 | Four phase drive lines |
| bridge_en_o | output | 2 | Enables for the two bridges |
| irq_o | output | 1 | High while the staging slot is free |

## Verification
The bench builds the controller with PRESCALE set to 4 instead of a real clock-to-10 kHz ratio, and with an 8-bit step total. At that ratio every interval, including the zero-treated-as-one case, spans only a handful of cycles. Exact step spacing, back-to-back queued moves and single steps blocked during a move can then all be observed within a short run. The phase monitor checks every transition against the sequence order and the spacing against interval × 4.

// File: rtl/stepper_pkg.sv
package stepper_pkg;

  localparam logic [1:0] OFS_CMD   = 2'd0;
  localparam logic [1:0] OFS_TOTAL = 2'd1;
  localparam logic [1:0] OFS_IVL   = 2'd2;

  localparam int unsigned B_RUN  = 7;
  localparam int unsigned B_SLOT = 6;
  localparam int unsigned B_DRV  = 5;
  localparam int unsigned B_GO   = 2;
  localparam int unsigned B_ONE  = 1;
  localparam int unsigned B_DIR  = 0;

  // full-step two-coil pattern for a position 0..3
  function automatic logic [3:0] coil_pattern(input logic [1:0] pos);
    logic [3:0] p;
    case (pos)
      2'd0:    p = 4'b0011;
      2'd1:    p = 4'b0110;
      2'd2:    p = 4'b1100;
      default: p = 4'b1001;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/stepper_prescale.sv
module stepper_prescale #(
  parameter int unsigned DIV = 10000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

  generate
    if (DIV <= 1) begin : g_pass
      assign tick_o = 1'b1;
    end else begin : g_div
      logic [CW-1:0] cnt_q, cnt_d;
      logic          wrap;

      always_comb begin
        wrap  = (cnt_q == CW'(DIV - 1));
        cnt_d = wrap ? '0 : cnt_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end

      assign tick_o = wrap;

      // R3: base tick is a single-cycle pulse
      p_tick_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
    end
  endgenerate

endmodule

// File: rtl/stepper_move.sv
module stepper_move #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned SPD_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             go_i,
  input  logic             go_dir_i,
  input  logic [CNT_W-1:0] stage_cnt_i,
  input  logic [SPD_W-1:0] stage_spd_i,
  output logic             busy_o,
  output logic             full_o,
  output logic             step_o,
  output logic             dir_o,
  output logic [CNT_W-1:0] remain_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [SPD_W-1:0] spd_q, spd_d, ivl_q, ivl_d, spd_eff;
  logic             full_q, full_d, sdir_q, sdir_d, wdir_q, wdir_d;
  logic             busy, load, step;

  always_comb begin
    busy    = (cnt_q != '0);
    load    = full_q && !busy;
    step    = busy && tick_i && ((ivl_q + SPD_W'(1)) == spd_q);
    spd_eff = (stage_spd_i == '0) ? SPD_W'(1) : stage_spd_i;

    cnt_d  = cnt_q;
    spd_d  = spd_q;
    ivl_d  = ivl_q;
    full_d = full_q;
    sdir_d = sdir_q;
    wdir_d = wdir_q;

    if (load) begin
      cnt_d  = stage_cnt_i;
      spd_d  = spd_eff;
      ivl_d  = '0;
      wdir_d = sdir_q;
      full_d = 1'b0;
    end else if (step) begin
      cnt_d = cnt_q - 1'b1;
      ivl_d = '0;
    end else if (busy && tick_i) begin
      ivl_d = ivl_q + 1'b1;
    end

    if (go_i) begin
      full_d = 1'b1;
      sdir_d = go_dir_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      spd_q  <= SPD_W'(1);
      ivl_q  <= '0;
      full_q <= 1'b0;
      sdir_q <= 1'b0;
      wdir_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      spd_q  <= spd_d;
      ivl_q  <= ivl_d;
      full_q <= full_d;
      sdir_q <= sdir_d;
      wdir_q <= wdir_d;
    end
  end

  assign busy_o   = busy;
  assign full_o   = full_q;
  assign step_o   = step;
  assign dir_o    = wdir_q;
  assign remain_o = cnt_q;

  // R5: every step removes exactly one from the remaining total
  p_count_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
    step_o |=> (remain_o == $past(remain_o) - 1'b1));

  // R4: a staged move waits while the running one still has steps left
  p_stage_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && (cnt_q > CNT_W'(1))) |=> full_q);

endmodule

// File: rtl/stepper_phase.sv
module stepper_phase
  import stepper_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       adv_i,
  input  logic       dir_i,
  input  logic       drv_en_i,
  output logic [3:0] phase_o,
  output logic [1:0] bridge_en_o
);
  logic [1:0] pos_q, pos_d;

  always_comb begin
    pos_d = pos_q;
    if (adv_i) pos_d = dir_i ? pos_q + 2'd1 : pos_q - 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= 2'd0;
    else        pos_q <= pos_d;
  end

  always_comb begin
    phase_o     = drv_en_i ? coil_pattern(pos_q) : 4'b0000;
    bridge_en_o = drv_en_i ? 2'b11 : 2'b00;
  end

  // R6: position moves only on a request, one place per request
  p_fwd_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && dir_i) |=> (pos_q == $past(pos_q) + 2'd1));
  p_rev_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !dir_i) |=> (pos_q == $past(pos_q) - 2'd1));
  p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_i |=> $stable(pos_q));

endmodule

// File: rtl/stepper_ctl.sv
module stepper_ctl
  import stepper_pkg::*;
#(
  parameter int unsigned PRESCALE = 10000,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned SPD_W    = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [3:0]        phase_o,
  output logic [1:0]        bridge_en_o,
  output logic              irq_o
);
  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic             tick, busy, full, mv_step, mv_dir;
  logic [CNT_W-1:0] remain;

  logic             drv_q, drv_d, dir_q, dir_d, one_q, one_d, odir_q, odir_d;
  logic [CNT_W-1:0] stg_cnt_q, stg_cnt_d;
  logic [SPD_W-1:0] stg_spd_q, stg_spd_d;
  logic             wr_cmd, go, adv, adv_dir;
  logic             unused_wdata;

  assign unused_wdata = ^bus_wdata;

  always_comb begin
    wr_cmd    = bus_wr && (bus_addr == OFS_CMD);
    go        = wr_cmd && bus_wdata[B_GO] && !bus_wdata[B_ONE];
    drv_d     = drv_q;
    dir_d     = dir_q;
    stg_cnt_d = stg_cnt_q;
    stg_spd_d = stg_spd_q;
    odir_d    = odir_q;
    one_d     = 1'b0;
    if (wr_cmd) begin
      drv_d = bus_wdata[B_DRV];
      dir_d = bus_wdata[B_DIR];
      if (bus_wdata[B_ONE] && !busy && !full) begin
        one_d  = 1'b1;
        odir_d = bus_wdata[B_DIR];
      end
    end
    if (bus_wr && (bus_addr == OFS_TOTAL)) stg_cnt_d = bus_wdata[CNT_W-1:0];
    if (bus_wr && (bus_addr == OFS_IVL))   stg_spd_d = bus_wdata[SPD_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      drv_q     <= 1'b0;
      dir_q     <= 1'b0;
      one_q     <= 1'b0;
      odir_q    <= 1'b0;
      stg_cnt_q <= '0;
      stg_spd_q <= '0;
    end else begin
      drv_q     <= drv_d;
      dir_q     <= dir_d;
      one_q     <= one_d;
      odir_q    <= odir_d;
      stg_cnt_q <= stg_cnt_d;
      stg_spd_q <= stg_spd_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_CMD: begin
        bus_rdata[B_RUN]  = busy;
        bus_rdata[B_SLOT] = full;
        bus_rdata[B_DRV]  = drv_q;
        bus_rdata[B_DIR]  = dir_q;
      end
      OFS_TOTAL: bus_rdata[CNT_W-1:0] = remain;
      OFS_IVL:   bus_rdata[SPD_W-1:0] = stg_spd_q;
      default:   bus_rdata = '0;
    endcase
  end

  assign adv     = mv_step || one_q;
  assign adv_dir = one_q ? odir_q : mv_dir;
  assign irq_o   = !full;

  stepper_prescale #(.DIV(PRESCALE)) i_prescale (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .tick_o (tick)
  );

  stepper_move #(.CNT_W(CNT_W), .SPD_W(SPD_W)) i_move (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .tick_i      (tick),
    .go_i        (go),
    .go_dir_i    (bus_wdata[B_DIR]),
    .stage_cnt_i (stg_cnt_q),
    .stage_spd_i (stg_spd_q),
    .busy_o      (busy),
    .full_o      (full),
    .step_o      (mv_step),
    .dir_o       (mv_dir),
    .remain_o    (remain)
  );

  stepper_phase i_phase (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .adv_i       (adv),
    .dir_i       (adv_dir),
    .drv_en_i    (drv_q),
    .phase_o     (phase_o),
    .bridge_en_o (bridge_en_o)
  );

  // R8: outputs dark whenever drive is off
  p_dark_when_off_r8: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !drv_q |-> (phase_o == 4'b0000 && bridge_en_o == 2'b00));

  // R7: a single step never coincides with a move step
  p_single_alone_r7: assert property (@(posedge clk) disable iff (!rst_sync_q)
    one_q |-> !mv_step);

endmodule

// File: tb/test_stepper_ctl.sv
`timescale 1ns/1ps
module test_stepper_ctl;
  localparam int unsigned PRE = 4;
  localparam int unsigned DW  = 16;

  typedef struct packed {
    logic        dir;
    logic [7:0]  cnt;
    logic [13:0] spd;
  } mv_t;

  localparam mv_t VEC [6] = '{
    '{1'b1, 8'd3, 14'd2},
    '{1'b0, 8'd4, 14'd1},
    '{1'b1, 8'd2, 14'd0},
    '{1'b0, 8'd5, 14'd3},
    '{1'b1, 8'd1, 14'd6},
    '{1'b1, 8'd6, 14'd1}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0;
  logic [1:0]    bus_addr = 2'd0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic [3:0]    phase_o;
  logic [1:0]    bridge_en_o;
  logic          irq_o;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  stepper_ctl #(.PRESCALE(PRE), .DATA_W(DW), .CNT_W(8), .SPD_W(14)) i_stepper_ctl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .phase_o(phase_o),
    .bridge_en_o(bridge_en_o), .irq_o(irq_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [3:0] nxt(input logic [3:0] p, input bit fwd);
    logic [3:0] s [4] = '{4'b0011, 4'b0110, 4'b1100, 4'b1001};
    int k = 0;
    for (int i = 0; i < 4; i++) if (s[i] == p) k = i;
    return fwd ? s[(k + 1) % 4] : s[(k + 3) % 4];
  endfunction

  // step monitor
  int         steps = 0;
  bit         exp_dir = 1'b1;
  bit         gap_chk = 1'b0;
  bit         have_last = 1'b0;
  int         exp_gap = 0;
  int         last_cyc = 0;
  logic [3:0] prev_ph = 4'b0;
  logic [1:0] prev_en = 2'b0;

  always @(negedge clk) begin
    if (rst_n && prev_en == 2'b11 && bridge_en_o == 2'b11 && phase_o != prev_ph) begin
      steps++;
      check(phase_o == nxt(prev_ph, exp_dir), "R6 sequence", phase_o, nxt(prev_ph, exp_dir));
      if (gap_chk && have_last)
        check(cyc - last_cyc == exp_gap, "R3 spacing", cyc - last_cyc, exp_gap);
      last_cyc  = cyc;
      have_last = 1'b1;
    end
    prev_ph = phase_o;
    prev_en = bridge_en_o;
  end

  task automatic wait_idle();
    logic [DW-1:0] d;
    idle(4);
    for (int k = 0; k < 2000; k++) begin
      rd(2'd0, d);
      if (!d[7] && !d[6]) break;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d;
    logic [3:0]    p_keep;
    int            s0;

    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    check(phase_o == 4'b0000, "R1 phase", phase_o, 0);
    check(bridge_en_o == 2'b00, "R1 bridge", bridge_en_o, 0);
    check(irq_o == 1'b1, "R1 irq", irq_o, 1);
    rd(2'd0, d);
    check(d == '0, "R1 status", d, 0);

    // R6 enable drive: first pattern
    wr(2'd0, 16'h0020);
    idle(1);
    check(phase_o == 4'b0011, "R6 first state", phase_o, 4'b0011);
    check(bridge_en_o == 2'b11, "R6 bridges", bridge_en_o, 3);

    // R3 R5 R6 vector walk
    foreach (VEC[i]) begin
      exp_dir   = VEC[i].dir;
      have_last = 1'b0;
      gap_chk   = 1'b1;
      exp_gap   = ((VEC[i].spd == 0) ? 1 : int'(VEC[i].spd)) * PRE;
      s0        = steps;
      wr(2'd1, {8'd0, VEC[i].cnt});
      wr(2'd2, {2'd0, VEC[i].spd});
      rd(2'd2, d);
      check(d == {2'd0, VEC[i].spd}, "R2 interval readback", d, VEC[i].spd);
      wr(2'd0, 16'h0024 | {15'd0, VEC[i].dir});
      wait_idle();
      check(steps - s0 == int'(VEC[i].cnt), "R5 step total", steps - s0, VEC[i].cnt);
      rd(2'd1, d);
      check(d == '0, "R5 remaining zero", d, 0);
    end
    gap_chk = 1'b0;

    // R7 single step while idle, start bit and staged total ignored
    exp_dir = 1'b1;
    wr(2'd1, 16'd9);
    s0 = steps;
    wr(2'd0, 16'h0027);
    idle(6);
    check(steps - s0 == 1, "R7 single step", steps - s0, 1);
    rd(2'd0, d);
    check(d[7:6] == 2'b00, "R7 no move started", d[7:6], 0);

    // R10 zero total
    s0 = steps;
    wr(2'd1, 16'd0);
    wr(2'd0, 16'h0025);
    idle(8);
    rd(2'd0, d);
    check(d[7] == 1'b0, "R10 not running", d[7], 0);
    check(steps == s0, "R10 no steps", steps - s0, 0);

    // R4 R9 queued move, R7 single step blocked while busy
    exp_dir = 1'b0;
    s0 = steps;
    wr(2'd1, 16'd3);
    wr(2'd2, 16'd5);
    wr(2'd0, 16'h0024);
    idle(3);
    rd(2'd0, d);
    check(d[7] == 1'b1, "R2 running flag", d[7], 1);
    rd(2'd1, d);
    check(d > 0 && d <= 3, "R2 remaining during move", d, 3);
    wr(2'd1, 16'd2);
    wr(2'd2, 16'd2);
    wr(2'd0, 16'h0024);
    rd(2'd0, d);
    check(d[6] == 1'b1, "R4 slot occupied", d[6], 1);
    check(irq_o == 1'b0, "R9 irq low when occupied", irq_o, 0);
    wr(2'd0, 16'h0022);
    for (int k = 0; k < 2000; k++) begin
      rd(2'd0, d);
      if (!d[6]) break;
    end
    check(irq_o == 1'b1, "R9 irq high when free", irq_o, 1);
    wait_idle();
    check(steps - s0 == 5, "R4 both moves ran, R7 blocked", steps - s0, 5);

    // R8 drive disable keeps position
    p_keep = phase_o;
    wr(2'd0, 16'h0000);
    idle(1);
    check(phase_o == 4'b0000, "R8 phase dark", phase_o, 0);
    check(bridge_en_o == 2'b00, "R8 bridges dark", bridge_en_o, 0);
    wr(2'd0, 16'h0020);
    idle(1);
    check(phase_o == p_keep, "R8 position kept", phase_o, p_keep);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule